// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns a buffer of character codes into a monochrome pixel stream for a 640x480-class display made of 8x8 character cells. Each clock it takes the horizontal pixel counter, the vertical line counter and an active-video flag from the display timing logic. It drives the address of a synchronous character-buffer RAM and the address of a synchronous font ROM. From the glyph row that comes back it emits one pixel. A set bit is shown as white on all three colour outputs and a clear bit as black.

A cell is eight pixels wide, so the block has eight clocks to prepare the next cell. It fetches the code of the next text column while the current column is still on screen. The timing logic presets the horizontal counter to 1016 before the line starts. Adding 8 to that value wraps to 0, so the fetch for column 0 happens during the eight clocks just before active video. The RAM read, the ROM read and the block's own address registers all fit inside that window. The glyph row is then held in one register while its eight bits are shifted out.

Top module: `textPixelGen`

## Requirements
- R1: While `activeVideo` is 1, all three bits of `pixelRgb` equal bit `7 - (xCount mod 8)` of the glyph row held for the current cell. Bit 7 is the leftmost pixel of a cell.
- R2: While `activeVideo` is 0, `pixelRgb` is 0, whatever glyph row is held.
- R3: `charAddr` changes only on the clock edge that ends a cycle with `xCount mod 8 == 0`. It then becomes `(yCount div 8) * COLS + ((xCount div 8 + 1) mod 128)`. This is the column after the one being drawn.
- R4: `fontAddr` changes only on the clock edge that ends a cycle with `xCount mod 8 == 3`. It then becomes `{charData, yCount[2:0]}`, with the character code in bits 10:3 and the line within the cell in bits 2:0.
- R5: The glyph row register loads `fontData` on the edge that ends a cycle with `xCount mod 8 == 7`. It holds that value for the next eight pixels.
- R6: While `rstN` is 0, `charAddr`, `fontAddr` and the held glyph row are 0, and so `pixelRgb` is 0.
- R7: With `xCount` stepping 1016..1023 before it wraps to 0, the first cell of a line shows text column 0 of the current text row. Its address is registered one clock after `xCount` = 1016.
- R8: With memories that have one clock of read latency, every pixel of every line matches the font bitmap of the code stored for its cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| xCount | input | 10 | Horizontal pixel counter, preset to 1016 before active video |
| yCount | input | 10 | Vertical line counter |
| activeVideo | input | 1 | High during visible pixels |
| charAddr | output | 13 | Character-buffer read address |
| charData | input | 8 | Character code, one clock after the address |
| fontAddr | output | 11 | Font ROM read address {code, line in cell} |
| fontData | input | 8 | Glyph row, one clock after the address |
| pixelRgb | output | 3 | Red, green, blue pixel value |

## Verification
The assertions assume that `xCount` steps by one each clock within a cell, so that its low three bits run 0 to 7 in order. They also assume that `yCount` stays constant from the preset cell to the end of the line, and that both memories answer exactly one clock after their address. The bench drives each line as eight preset values 1016..1023, then 0..639 with the flag high, then sixteen blanking pixels. Its memory models register a computed function of the address. A reset phase and a line with the flag held low both keep the counter sequence intact, so these assumptions are never broken.

// File: rtl/textPixelPkg.sv
`timescale 1ns/1ps
package textPixelPkg;
  typedef struct packed {
    logic loadCharAddr;
    logic loadFontAddr;
    logic loadGlyph;
  } cellStrobes_t;
endpackage

// File: rtl/textPixelCtrl.sv
`timescale 1ns/1ps
// Decodes the pixel phase within a cell into the fetch-schedule strobes.
module textPixelCtrl
  import textPixelPkg::*;
#(
  parameter int PHASE_W  = 3,
  parameter int CHAR_PH  = 0,
  parameter int FONT_PH  = 3,
  parameter int GLYPH_PH = 7
) (
  input  logic [PHASE_W-1:0] cellPhase,
  output cellStrobes_t       strobes
);
  localparam logic [PHASE_W-1:0] CharPhase  = PHASE_W'(CHAR_PH);
  localparam logic [PHASE_W-1:0] FontPhase  = PHASE_W'(FONT_PH);
  localparam logic [PHASE_W-1:0] GlyphPhase = PHASE_W'(GLYPH_PH);

  always_comb begin
    strobes.loadCharAddr = (cellPhase == CharPhase);
    strobes.loadFontAddr = (cellPhase == FontPhase);
    strobes.loadGlyph    = (cellPhase == GlyphPhase);
  end
endmodule

// File: rtl/textPixelData.sv
`timescale 1ns/1ps
// Address registers, glyph-row holding register and pixel bit selection.
module textPixelData
  import textPixelPkg::*;
#(
  parameter int X_W         = 10,
  parameter int Y_W         = 10,
  parameter int CODE_W      = 8,
  parameter int CELL_W      = 8,
  parameter int COLS        = 80,
  parameter int CHAR_ADDR_W = 13,
  parameter int COLOR_CH    = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cellStrobes_t                  strobes,
  input  logic [X_W-1:0]                xCount,
  input  logic [Y_W-1:0]                yCount,
  input  logic                          activeVideo,
  input  logic [CODE_W-1:0]             charData,
  input  logic [CELL_W-1:0]             fontData,
  output logic [CHAR_ADDR_W-1:0]        charAddr,
  output logic [CODE_W+$clog2(CELL_W)-1:0] fontAddr,
  output logic [COLOR_CH-1:0]           pixelRgb
);
  localparam int SHIFT  = $clog2(CELL_W);
  localparam int COL_W  = X_W - SHIFT;
  localparam int ROW_W  = Y_W - SHIFT;
  localparam int WIDE_W = X_W + Y_W;

  logic [COL_W-1:0]  nextCol;
  logic [ROW_W-1:0]  textRow;
  logic [WIDE_W-1:0] addrWide;
  logic [CELL_W-1:0] glyphRow;
  logic              pixBit;

  // Next column: the counter preset below zero wraps this to column 0.
  assign nextCol  = xCount[X_W-1:SHIFT] + COL_W'(1);
  assign textRow  = yCount[Y_W-1:SHIFT];
  assign addrWide = WIDE_W'(textRow) * WIDE_W'(COLS) + WIDE_W'(nextCol);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charAddr <= '0;
      fontAddr <= '0;
      glyphRow <= '0;
    end else begin
      if (strobes.loadCharAddr) charAddr <= addrWide[CHAR_ADDR_W-1:0];
      if (strobes.loadFontAddr) fontAddr <= {charData, yCount[SHIFT-1:0]};
      if (strobes.loadGlyph)    glyphRow <= fontData;
    end
  end

  // Leftmost pixel is the most significant bit of the glyph row.
  assign pixBit = glyphRow[~xCount[SHIFT-1:0]];

  for (genvar ch = 0; ch < COLOR_CH; ch++) begin : g_chan
    assign pixelRgb[ch] = activeVideo & pixBit;
  end
endmodule

// File: rtl/textPixelGen.sv
`timescale 1ns/1ps
module textPixelGen
  import textPixelPkg::*;
#(
  parameter int X_W      = 10,
  parameter int Y_W      = 10,
  parameter int CODE_W   = 8,
  parameter int CELL_W   = 8,
  parameter int COLS     = 80,
  parameter int ROWS     = 60,
  parameter int MEM_LAT  = 1,
  parameter int COLOR_CH = 3,
  localparam int SHIFT       = $clog2(CELL_W),
  localparam int CHAR_ADDR_W = $clog2(COLS * ROWS),
  localparam int FONT_ADDR_W = CODE_W + SHIFT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [X_W-1:0]         xCount,
  input  logic [Y_W-1:0]         yCount,
  input  logic                   activeVideo,
  output logic [CHAR_ADDR_W-1:0] charAddr,
  input  logic [CODE_W-1:0]      charData,
  output logic [FONT_ADDR_W-1:0] fontAddr,
  input  logic [CELL_W-1:0]      fontData,
  output logic [COLOR_CH-1:0]    pixelRgb
);
  // Schedule: address register, memory latency, one cycle of slack.
  localparam int CHAR_PH  = 0;
  localparam int FONT_PH  = CHAR_PH + MEM_LAT + 2;
  localparam int GLYPH_PH = CELL_W - 1;

  cellStrobes_t strobes;

  textPixelCtrl #(
    .PHASE_W (SHIFT),
    .CHAR_PH (CHAR_PH),
    .FONT_PH (FONT_PH),
    .GLYPH_PH(GLYPH_PH)
  ) i_ctrl (
    .cellPhase(xCount[SHIFT-1:0]),
    .strobes  (strobes)
  );

  textPixelData #(
    .X_W        (X_W),
    .Y_W        (Y_W),
    .CODE_W     (CODE_W),
    .CELL_W     (CELL_W),
    .COLS       (COLS),
    .CHAR_ADDR_W(CHAR_ADDR_W),
    .COLOR_CH   (COLOR_CH)
  ) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .xCount     (xCount),
    .yCount     (yCount),
    .activeVideo(activeVideo),
    .charData   (charData),
    .fontData   (fontData),
    .charAddr   (charAddr),
    .fontAddr   (fontAddr),
    .pixelRgb   (pixelRgb)
  );
endmodule

// File: rtl/textPixelGenChk.sv
`timescale 1ns/1ps
module textPixelGenChk #(
  parameter int X_W         = 10,
  parameter int Y_W         = 10,
  parameter int CELL_W      = 8,
  parameter int CHAR_ADDR_W = 13,
  parameter int FONT_ADDR_W = 11,
  parameter int COLOR_CH    = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [X_W-1:0]         xCount,
  input logic [Y_W-1:0]         yCount,
  input logic                   activeVideo,
  input logic [CHAR_ADDR_W-1:0] charAddr,
  input logic [FONT_ADDR_W-1:0] fontAddr,
  input logic [CELL_W-1:0]      fontData,
  input logic [COLOR_CH-1:0]    pixelRgb
);
  localparam int SHIFT = $clog2(CELL_W);
  logic [SHIFT-1:0] phase;
  assign phase = xCount[SHIFT-1:0];

  a_r2_blank_black: assert property (@(posedge clk) disable iff (!rstN)
    !activeVideo |-> pixelRgb == '0);

  a_r1_white_or_black: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> ($countones(pixelRgb) == 0 || $countones(pixelRgb) == COLOR_CH));

  a_r3_char_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    phase != SHIFT'(0) |=> $stable(charAddr));

  a_r4_font_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    phase != SHIFT'(3) |=> $stable(fontAddr));

  a_r4_font_line: assert property (@(posedge clk) disable iff (!rstN)
    phase == SHIFT'(3) |=> fontAddr[SHIFT-1:0] == $past(yCount[SHIFT-1:0]));

  a_r5_glyph_load: assert property (@(posedge clk) disable iff (!rstN)
    (phase == SHIFT'(7)) ##1 (activeVideo && phase == SHIFT'(0))
      |-> pixelRgb[0] == $past(fontData[CELL_W-1]));

  a_r6_reset_black: assert property (@(posedge clk)
    $past(!rstN) && !rstN |-> pixelRgb == '0 && charAddr == '0 && fontAddr == '0);
endmodule

bind textPixelGen textPixelGenChk #(
  .X_W        (X_W),
  .Y_W        (Y_W),
  .CELL_W     (CELL_W),
  .CHAR_ADDR_W(CHAR_ADDR_W),
  .FONT_ADDR_W(FONT_ADDR_W),
  .COLOR_CH   (COLOR_CH)
) i_textPixelGenChk (
  .clk        (clk),
  .rstN       (rstN),
  .xCount     (xCount),
  .yCount     (yCount),
  .activeVideo(activeVideo),
  .charAddr   (charAddr),
  .fontAddr   (fontAddr),
  .fontData   (fontData),
  .pixelRgb   (pixelRgb)
);

// File: tb/test_textPixelGen.sv
`timescale 1ns/1ps
module test_textPixelGen;
  localparam int COLS  = 80;
  localparam int ROWS  = 4;
  localparam int LINES = ROWS * 8;
  localparam int AW    = $clog2(COLS * ROWS);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [9:0]     xCount = '0;
  logic [9:0]     yCount = '0;
  logic           activeVideo = 1'b0;
  logic [AW-1:0]  charAddr;
  logic [7:0]     charData = '0;
  logic [10:0]    fontAddr;
  logic [7:0]     fontData = '0;
  logic [2:0]     pixelRgb;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  textPixelGen #(.COLS(COLS), .ROWS(ROWS)) i_textPixelGen (
    .clk(clk), .rstN(rstN), .xCount(xCount), .yCount(yCount),
    .activeVideo(activeVideo), .charAddr(charAddr), .charData(charData),
    .fontAddr(fontAddr), .fontData(fontData), .pixelRgb(pixelRgb)
  );

  function automatic logic [7:0] charFn(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] fontFn(int a);
    int code = a >> 3;
    int row  = a & 7;
    return 8'((code * 37) ^ (row * 83) ^ (code >> 3));
  endfunction

  // Memory models: one registered read stage each.
  always @(posedge clk) begin
    charData <= charFn(int'(charAddr));
    fontData <= fontFn(int'(fontAddr));
  end

  function automatic logic [2:0] expRgb(int xv, int y, bit act);
    logic [7:0] code, g;
    if (!act) return 3'b000;
    code = charFn((y / 8) * COLS + xv / 8);
    g    = fontFn(int'(code) * 8 + y % 8);
    return {3{g[7 - xv % 8]}};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One display line: preset cell, 640 visible pixels, 16 blanking pixels.
  task automatic runLine(int y, int expFirstAddr, bit actEn);
    for (int idx = 0; idx < 664; idx++) begin
      int  xv  = (idx < 8) ? 1016 + idx : idx - 8;
      bit  act = actEn && idx >= 8 && idx < 648;
      @(negedge clk);
      xCount = 10'(xv); yCount = 10'(y); activeVideo = act;
      #1;
      if (idx == 1)
        check(charAddr == AW'(expFirstAddr), "R7/R3 first column address",
              int'(charAddr), expFirstAddr);
      if (idx == 4)
        check(fontAddr == {charFn(expFirstAddr), 3'(y)}, "R4 font address",
              int'(fontAddr), int'({charFn(expFirstAddr), 3'(y)}));
      if (actEn)
        check(pixelRgb == expRgb(xv, y, act), "R1/R5/R8 pixel",
              int'(pixelRgb), int'(expRgb(xv, y, act)));
      else
        check(pixelRgb == 3'b000, "R2 blanked pixel", int'(pixelRgb), 0);
    end
  endtask

  // {line, expected address of column 0}
  localparam int VEC[6][2] = '{'{0, 0}, '{3, 0}, '{7, 0}, '{8, 80}, '{17, 160}, '{31, 240}};

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R6: reset state with video flagged active.
    activeVideo = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(pixelRgb == 3'b000, "R6 reset pixel", int'(pixelRgb), 0);
    check(charAddr == '0, "R6 reset charAddr", int'(charAddr), 0);
    check(fontAddr == '0, "R6 reset fontAddr", int'(fontAddr), 0);
    @(negedge clk);
    rstN = 1'b1;
    activeVideo = 1'b0;

    // Table walk.
    foreach (VEC[i]) runLine(VEC[i][0], VEC[i][1], 1'b1);

    // R8: a whole frame, line by line.
    for (int y = 0; y < LINES; y++) runLine(y, (y / 8) * COLS, 1'b1);

    // R2: a full line with the flag low, after glyphs were loaded.
    runLine(9, COLS, 1'b0);

    // Frame restarts cleanly at the top.
    runLine(0, 0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule